// File: doc/BRIEF.md
# Cascadable Synchronous BCD Counter Stage

This block is one decimal digit of a synchronous counter. It holds a 4-bit binary-coded decimal value that steps 0, 1, ... 9, 0 on the rising clock edge. Several stages share one clock. Each stage's carry output feeds the chain-enable input of the next stage, so a row of stages counts in decimal and every digit changes on the same edge.

Two enables gate counting. The chain enable also gates the carry output, so it is the input a lower digit drives. The parallel enable only gates counting, so a single global run/stop signal can drive it without disturbing carry propagation. A synchronous parallel load and a synchronous clear complete the stage. Because the clear acts only on an edge, decoding count N−1 across a chain and driving every clear low gives a clean divide-by-N with exactly N states.

Top module: `bcd_count_stage`

## Requirements
- R1: While `rst_n` is low, `count` is 0 at once, without waiting for a clock edge.
- R2: On a rising edge with `en_chain`, `en_par`, `sload_n` and `sclr_n` all high, `count` increases by one.
- R3: An enabled count edge taken from 9 gives 0, so the legal sequence is 0 to 9.
- R4: With `sclr_n` and `sload_n` high and either `en_chain` or `en_par` low, `count` keeps its value across the edge.
- R5: `sclr_n` low at a rising edge makes `count` 0. This holds whatever the load, enable and data inputs are.
- R6: A low pulse on `sclr_n` that starts and ends between two rising edges leaves `count` unchanged.
- R7: With `sclr_n` high and `sload_n` low at a rising edge, `count` takes `load_val`. This holds with either enable low.
- R8: `carry_out` is high exactly when `count` is 9 and `en_chain` is high. It follows `en_chain` without waiting for a clock, and `en_par` has no effect on it.
- R9: After a load of a value from 10 to 15, `carry_out` stays low and the next enabled count edge gives 0.
- R10: In a chain of stages on one clock, with each carry driving the next stage's `en_chain`, the digits count in decimal. Decoding count N−1 onto every `sclr_n` gives a repeating sequence of exactly N states (0 to 78 for N = 79).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all chained stages |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en_chain | input | 1 | Count enable that also gates `carry_out` |
| en_par | input | 1 | Count enable that does not affect `carry_out` |
| sclr_n | input | 1 | Synchronous active-low clear |
| sload_n | input | 1 | Synchronous active-low parallel load |
| load_val | input | 4 | Value taken on a load edge |
| count | output | 4 | Present BCD digit |
| carry_out | output | 1 | Terminal-count carry to the next stage |

## Verification
A behavioural model of the digit is compared after every edge. The stimulus includes free counting through several wraps, which separates the 9-to-0 rollover from plain binary counting. It also lowers each enable in turn. With the count held at 9, this exposes any mix-up of which enable gates the carry. Loads and clears are applied together and against the enables to pin down priority. A clear pulse placed between edges and loads of 10 to 15 check edge-only clearing and recovery from illegal values. A two-digit chain with a decoded clear runs free and is checked each cycle against a modulo-79 model, which separates same-edge carry propagation from any late or early digit step.

// File: rtl/bcd_stage_pkg.sv
package bcd_stage_pkg;

  // Action selected for the coming clock edge, in priority order (clear highest)
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_COUNT = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } stage_act_e;

endpackage

// File: rtl/bcd_stage_ctrl.sv
module bcd_stage_ctrl
  import bcd_stage_pkg::*;
(
  input  logic       sclr_n,
  input  logic       sload_n,
  input  logic       en_chain,
  input  logic       en_par,
  output stage_act_e act
);

  // Fixed priority: clear, load, count, hold
  always_comb begin
    if (!sclr_n)                  act = ACT_CLEAR;
    else if (!sload_n)            act = ACT_LOAD;
    else if (en_chain && en_par)  act = ACT_COUNT;
    else                          act = ACT_HOLD;
  end

endmodule

// File: rtl/bcd_stage_next.sv
module bcd_stage_next
  import bcd_stage_pkg::*;
#(
  parameter int DIGIT_W  = 4,
  parameter int LAST_VAL = 9
) (
  input  stage_act_e         act,
  input  logic [DIGIT_W-1:0] cur,
  input  logic [DIGIT_W-1:0] load_val,
  output logic [DIGIT_W-1:0] nxt
);

  localparam logic [DIGIT_W-1:0] LAST_D = DIGIT_W'(LAST_VAL);
  localparam logic [DIGIT_W-1:0] ONE_D  = DIGIT_W'(1);

  logic [DIGIT_W-1:0] step;

  // Terminal value and every value above it wrap to zero
  always_comb begin
    if (cur >= LAST_D) step = '0;
    else               step = cur + ONE_D;
  end

  always_comb begin
    unique case (act)
      ACT_CLEAR: nxt = '0;
      ACT_LOAD:  nxt = load_val;
      ACT_COUNT: nxt = step;
      default:   nxt = cur;
    endcase
  end

endmodule

// File: rtl/bcd_stage_carry.sv
module bcd_stage_carry #(
  parameter int DIGIT_W  = 4,
  parameter int LAST_VAL = 9
) (
  input  logic [DIGIT_W-1:0] cur,
  input  logic               en_chain,
  output logic               carry_out
);

  localparam logic [DIGIT_W-1:0] LAST_D = DIGIT_W'(LAST_VAL);

  // Combinational terminal detect, gated only by the chain enable
  always_comb carry_out = en_chain && (cur == LAST_D);

endmodule

// File: rtl/bcd_count_stage.sv
module bcd_count_stage
  import bcd_stage_pkg::*;
#(
  parameter int DIGIT_W  = 4,
  parameter int LAST_VAL = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_chain,
  input  logic               en_par,
  input  logic               sclr_n,
  input  logic               sload_n,
  input  logic [DIGIT_W-1:0] load_val,
  output logic [DIGIT_W-1:0] count,
  output logic               carry_out
);

  localparam logic [DIGIT_W-1:0] LAST_D = DIGIT_W'(LAST_VAL);

  stage_act_e         act;
  logic [DIGIT_W-1:0] cnt_q;
  logic [DIGIT_W-1:0] cnt_d;
  logic               cnt_en;

  bcd_stage_ctrl u_ctrl (
    .sclr_n   (sclr_n),
    .sload_n  (sload_n),
    .en_chain (en_chain),
    .en_par   (en_par),
    .act      (act)
  );

  bcd_stage_next #(
    .DIGIT_W  (DIGIT_W),
    .LAST_VAL (LAST_VAL)
  ) u_next (
    .act      (act),
    .cur      (cnt_q),
    .load_val (load_val),
    .nxt      (cnt_d)
  );

  bcd_stage_carry #(
    .DIGIT_W  (DIGIT_W),
    .LAST_VAL (LAST_VAL)
  ) u_carry (
    .cur       (cnt_q),
    .en_chain  (en_chain),
    .carry_out (carry_out)
  );

  // Clock enable: the register only loads when an action other than hold is chosen
  always_comb cnt_en = (act != ACT_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |-> cnt_q == '0); // R1

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sclr_n && sload_n && en_chain && en_par && cnt_q < LAST_D)
      |=> cnt_q == $past(cnt_q) + DIGIT_W'(1)); // R2

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sclr_n && sload_n && en_chain && en_par && cnt_q >= LAST_D)
      |=> cnt_q == '0); // R3

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sclr_n && sload_n && !(en_chain && en_par)) |=> $stable(cnt_q)); // R4

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    !sclr_n |=> cnt_q == '0); // R5

  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (sclr_n && !sload_n) |=> cnt_q == $past(load_val)); // R7

  AST_CARRY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |-> (en_chain && cnt_q == LAST_D)); // R8

endmodule

// File: tb/bcd_count_stage_tb_top.sv
`timescale 1ns/1ps
module bcd_count_stage_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_chain = 1'b0;
  logic       en_par = 1'b0;
  logic       sclr_n = 1'b1;
  logic       sload_n = 1'b1;
  logic [3:0] load_val = 4'd0;
  logic [3:0] count;
  logic       carry_out;

  int n_checks = 0;
  int n_fails  = 0;
  int model    = 0;
  int div_model = 0;

  always #2 clk = ~clk; // 250 MHz

  bcd_count_stage dut_i (
    .clk(clk), .rst_n(rst_n), .en_chain(en_chain), .en_par(en_par),
    .sclr_n(sclr_n), .sload_n(sload_n), .load_val(load_val),
    .count(count), .carry_out(carry_out)
  );

  // Two-digit divide-by-79 chain (R10)
  logic [3:0] lo_q, hi_q;
  logic       lo_cy, hi_cy;
  logic       div_clr_n;
  assign div_clr_n = !(hi_q == 4'd7 && lo_q == 4'd8);

  bcd_count_stage u_lo (
    .clk(clk), .rst_n(rst_n), .en_chain(1'b1), .en_par(1'b1),
    .sclr_n(div_clr_n), .sload_n(1'b1), .load_val(4'd0),
    .count(lo_q), .carry_out(lo_cy)
  );
  bcd_count_stage u_hi (
    .clk(clk), .rst_n(rst_n), .en_chain(lo_cy), .en_par(1'b1),
    .sclr_n(div_clr_n), .sload_n(1'b1), .load_val(4'd0),
    .count(hi_q), .carry_out(hi_cy)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Divider checked each negedge against a modulo-79 model
  always @(negedge clk) begin
    if (!rst_n) div_model = 0;
    else begin
      check("R10", int'(hi_q) * 10 + int'(lo_q), div_model);
      div_model = (div_model == 78) ? 0 : div_model + 1;
    end
  end

  // One cycle: drive at negedge, check carry, update model at edge, check count
  task automatic cyc(input logic ec, input logic ep, input logic ld_n,
                     input logic cl_n, input int val, input string req);
    @(negedge clk);
    en_chain = ec; en_par = ep; sload_n = ld_n; sclr_n = cl_n;
    load_val = 4'(val);
    #0.5;
    check("R8", int'(carry_out), (ec && model == 9) ? 1 : 0);
    @(posedge clk);
    if (!cl_n)            model = 0;
    else if (!ld_n)       model = val;
    else if (ec && ep)    model = (model >= 9) ? 0 : model + 1;
    #1;
    check(req, int'(count), model);
  endtask

  initial begin
    #(200000 * 4);
    n_fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    #3;
    check("R1", int'(count), 0);
    @(posedge clk); #1; rst_n = 1'b1;

    // R2 / R3: free counting through two wraps
    for (int i = 0; i < 23; i++) cyc(1, 1, 1, 1, 0, (model == 9) ? "R3" : "R2");

    // R4: hold with each enable low
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, 1, 0, "R4");
    for (int i = 0; i < 3; i++) cyc(1, 0, 1, 1, 0, "R4");

    // R7 / R8: load 9 with enables off, then carry vs each enable
    cyc(0, 0, 0, 1, 9, "R7");
    cyc(1, 0, 1, 1, 0, "R4");
    cyc(0, 1, 1, 1, 0, "R4");
    cyc(1, 1, 1, 1, 0, "R3");
    cyc(0, 0, 0, 1, 6, "R7");
    cyc(1, 1, 0, 1, 3, "R7");

    // R5: clear beats load and count
    cyc(1, 1, 0, 0, 7, "R5");
    cyc(0, 0, 0, 1, 9, "R7");
    cyc(1, 1, 1, 0, 0, "R5");

    // R6: clear pulse between edges
    cyc(0, 0, 0, 1, 4, "R7");
    @(negedge clk); en_chain = 1'b0; en_par = 1'b0; sload_n = 1'b1;
    sclr_n = 1'b0; #0.5; sclr_n = 1'b1;
    @(posedge clk); #1;
    check("R6", int'(count), 4);

    // R9: illegal loads recover to zero, no carry
    cyc(0, 0, 0, 1, 12, "R9");
    cyc(1, 0, 1, 1, 0, "R9");
    check("R9", int'(carry_out), 0);
    cyc(1, 1, 1, 1, 0, "R9");
    cyc(1, 1, 0, 1, 15, "R9");
    cyc(1, 1, 1, 1, 0, "R9");

    // R1: asynchronous reset mid-run
    cyc(0, 0, 0, 1, 5, "R7");
    @(posedge clk); #1; rst_n = 1'b0;
    #0.5;
    check("R1", int'(count), 0);
    model = 0;
    @(posedge clk); #1; rst_n = 1'b1;
    cyc(1, 1, 1, 1, 0, "R2");

    // Let the divider run more than two full periods
    for (int i = 0; i < 180; i++) cyc(1, 1, 1, 1, 0, (model == 9) ? "R3" : "R2");

    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule